// File: doc/BRIEF.md
# Transparent BISYNC Receive Character Filter

This block sits after a character-aligned BISYNC receiver and ahead of the logic that fills receive buffers. A strobe presents each received character to the filter. For each one it decides whether the character goes into the buffer, whether it feeds the block check sequence (BCS) accumulator, whether the current buffer must be closed, and whether an error or a control interrupt is raised. It removes SYNC fill characters. In transparent mode it also handles the escape character (DLE). A DLE is dropped, and the character that follows it selects the action: a SYNC is dropped, a second DLE is kept once, and any other character is looked up in a small programmable control table. A character found nowhere closes the buffer with an error.

The decision for a character appears on the registered outputs one clock after its strobe, together with a copy of the character. SYNC and DLE values are compared over the full character width, so with 7-bit characters plus parity the programmed values must include the parity bit. A write port loads the control table. Each entry has a valid bit, a character value, and an action bit. The action either writes the character and closes the buffer, or drops the character and raises a control interrupt.

Top module: `bsync_rx_filter`

## Requirements
- R1: After reset every output is 0, the filter is in its normal (non-escape) state, and every control-table entry is invalid.
- R2: When `hunt` is 0 and `sync_en` is 1, a strobed character equal to `sync_char` is dropped: `out_write` and `out_bcs` are 0 one cycle later, in either state.
- R3: When `hunt` is 1 or `sync_en` is 0, a character equal to `sync_char` in the normal state is data (`out_write`=1, `out_bcs`=1).
- R4: With `transparent`=1 and `dle_en`=1, a DLE in the normal state is dropped (`out_write`=0, `out_bcs`=0) and the filter enters the escape state.
- R5: In the escape state a SYNC (with `sync_en`=1) is dropped, and the filter returns to the normal state.
- R6: In the escape state a DLE is written and included in the BCS exactly once, and the filter returns to the normal state. Every written character is also included in the BCS.
- R7: In the escape state a character matching a valid table entry whose action bit is 1 is written, included in the BCS, and `out_close` pulses.
- R8: In the escape state a character matching a valid table entry whose action bit is 0 is dropped, is not included in the BCS, and `out_ctl_irq` pulses.
- R9: In the escape state a character that is neither SYNC nor DLE and matches no valid entry pulses `out_close` and `out_dle_err` and is not written. After any close the filter is in the normal state.
- R10: When `dle_en` is 0 or `transparent` is 0, a DLE is ordinary data and no escape state is entered.
- R11: SYNC and DLE matching uses all `W` bits. A character that differs from `sync_char` only in bit 7 is data.
- R12: When several valid entries match, the lowest index decides the action. Invalid entries never match.
- R13: `out_valid` pulses exactly one cycle after each strobe and `out_char` carries that character. Without a strobe, all action outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character strobe |
| in_char | input | W | Received character |
| sync_char | input | W | SYNC compare value |
| sync_en | input | 1 | SYNC compare enable |
| dle_char | input | W | DLE compare value |
| dle_en | input | 1 | DLE compare enable |
| transparent | input | 1 | Transparent mode |
| hunt | input | 1 | Receiver is hunting for sync |
| tbl_we | input | 1 | Control-table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_ent_valid | input | 1 | Entry valid bit |
| tbl_ent_char | input | W | Entry character |
| tbl_ent_close | input | 1 | Entry action: 1 write and close, 0 drop and interrupt |
| out_valid | output | 1 | Decision valid, one cycle after strobe |
| out_char | output | W | Character the decision applies to |
| out_write | output | 1 | Write character to buffer |
| out_bcs | output | 1 | Include character in BCS |
| out_close | output | 1 | Close buffer |
| out_dle_err | output | 1 | DLE follow-character error |
| out_ctl_irq | output | 1 | Control-character interrupt |

## Verification
The bench targets the escape sequences, where a wrong design shows a clear symptom. A filter that forgets to leave the escape state after DLE-DLE treats the next plain character as an escape follower and closes the buffer in error. A filter that writes both halves of a DLE-DLE pair produces a doubled character. The bench checks that a SYNC is not stripped while hunting or when disabled, and that a SYNC differing only in its top bit passes as data; a design comparing seven bits would drop that character. It places duplicate and invalid table entries so that a reversed priority or an ignored valid bit yields the wrong action. It also sends a plain character after each close, to catch a filter that stays in the escape state.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  typedef enum logic {ST_NORM = 1'b0, ST_ESC = 1'b1} bsf_state_t;

  typedef struct packed {
    logic wr;
    logic bcs;
    logic close;
    logic dle_err;
    logic irq;
  } bsf_act_t;

  localparam bsf_act_t ACT_NONE = '{wr: 1'b0, bcs: 1'b0, close: 1'b0, dle_err: 1'b0, irq: 1'b0};
endpackage

// File: rtl/bsf_ctl_table.sv
module bsf_ctl_table #(
  parameter int W       = 8,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wvalid,
  input  logic [W-1:0]     wchar,
  input  logic             wclose,
  input  logic [W-1:0]     key,
  output logic             hit,
  output logic             hit_close
);
  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] ent_c;
  logic [W-1:0]       ent_ch [ENTRIES];
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_v[g]  <= 1'b0;
          ent_c[g]  <= 1'b0;
          ent_ch[g] <= '0;
        end else if (we && (widx == IDX_W'(g))) begin
          ent_v[g]  <= wvalid;
          ent_c[g]  <= wclose;
          ent_ch[g] <= wchar;
        end
      end
      assign match[g] = ent_v[g] && (ent_ch[g] == key);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hit       = 1'b0;
    hit_close = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit       = 1'b1;
        hit_close = ent_c[i];
      end
    end
  end
endmodule

// File: rtl/bsf_escape_fsm.sv
module bsf_escape_fsm
  import bsf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [W-1:0] in_char,
  input  logic [W-1:0] sync_char,
  input  logic       sync_en,
  input  logic [W-1:0] dle_char,
  input  logic       dle_en,
  input  logic       transparent,
  input  logic       hunt,
  input  logic       tbl_hit,
  input  logic       tbl_close,
  output bsf_act_t   act,
  output logic       in_escape
);
  bsf_state_t state, state_nxt;
  logic is_sync, is_dle;

  assign is_sync   = sync_en && (in_char == sync_char);
  assign is_dle    = (in_char == dle_char);
  assign in_escape = (state == ST_ESC);

  always_comb begin
    act       = ACT_NONE;
    state_nxt = state;
    if (in_valid) begin
      if (state == ST_NORM) begin
        if (!hunt && is_sync) begin
          act = ACT_NONE;
        end else if (transparent && dle_en && is_dle) begin
          state_nxt = ST_ESC;
        end else begin
          act.wr  = 1'b1;
          act.bcs = 1'b1;
        end
      end else begin
        state_nxt = ST_NORM;
        if (is_sync) begin
          act = ACT_NONE;
        end else if (is_dle) begin
          act.wr  = 1'b1;
          act.bcs = 1'b1;
        end else if (tbl_hit) begin
          if (tbl_close) begin
            act.wr    = 1'b1;
            act.bcs   = 1'b1;
            act.close = 1'b1;
          end else begin
            act.irq = 1'b1;
          end
        end else begin
          act.close   = 1'b1;
          act.dle_err = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NORM;
    else     state <= state_nxt;
  end
endmodule

// File: rtl/bsync_rx_filter.sv
module bsync_rx_filter
  import bsf_pkg::*;
#(
  parameter int W       = 8,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_char,
  input  logic [W-1:0]     sync_char,
  input  logic             sync_en,
  input  logic [W-1:0]     dle_char,
  input  logic             dle_en,
  input  logic             transparent,
  input  logic             hunt,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic             tbl_ent_valid,
  input  logic [W-1:0]     tbl_ent_char,
  input  logic             tbl_ent_close,
  output logic             out_valid,
  output logic [W-1:0]     out_char,
  output logic             out_write,
  output logic             out_bcs,
  output logic             out_close,
  output logic             out_dle_err,
  output logic             out_ctl_irq
);
  logic     hit, hit_close, in_escape;
  bsf_act_t act;

  bsf_ctl_table #(.W(W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .wvalid(tbl_ent_valid),
    .wchar(tbl_ent_char), .wclose(tbl_ent_close), .key(in_char),
    .hit(hit), .hit_close(hit_close)
  );

  bsf_escape_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .sync_char(sync_char), .sync_en(sync_en), .dle_char(dle_char), .dle_en(dle_en),
    .transparent(transparent), .hunt(hunt), .tbl_hit(hit), .tbl_close(hit_close),
    .act(act), .in_escape(in_escape)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_char    <= '0;
      out_write   <= 1'b0;
      out_bcs     <= 1'b0;
      out_close   <= 1'b0;
      out_dle_err <= 1'b0;
      out_ctl_irq <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      if (in_valid) out_char <= in_char;
      out_write   <= act.wr;
      out_bcs     <= act.bcs;
      out_close   <= act.close;
      out_dle_err <= act.dle_err;
      out_ctl_irq <= act.irq;
    end
  end
endmodule

// File: rtl/bsync_rx_filter_chk.sv
module bsync_rx_filter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_char,
  input logic [W-1:0] sync_char,
  input logic         sync_en,
  input logic         hunt,
  input logic         out_valid,
  input logic         out_write,
  input logic         out_bcs,
  input logic         out_close,
  input logic         out_dle_err,
  input logic         out_ctl_irq
);
  // R2
  sync_strip_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !hunt && sync_en && (in_char == sync_char)) |-> (!out_write && !out_bcs));

  // R6
  write_in_bcs_chk: assert property (@(posedge clk) disable iff (rst)
    out_write |-> out_bcs);

  // R8
  irq_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_ctl_irq |-> (!out_write && !out_bcs && !out_close));

  // R9
  dle_err_close_chk: assert property (@(posedge clk) disable iff (rst)
    out_dle_err |-> (out_close && !out_write && !out_bcs));

  // R13
  act_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (out_write || out_bcs || out_close || out_ctl_irq) |-> (out_valid && $past(in_valid)));
endmodule

bind bsync_rx_filter bsync_rx_filter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
  .sync_char(sync_char), .sync_en(sync_en), .hunt(hunt),
  .out_valid(out_valid), .out_write(out_write), .out_bcs(out_bcs),
  .out_close(out_close), .out_dle_err(out_dle_err), .out_ctl_irq(out_ctl_irq)
);

// File: tb/bsync_rx_filter_tb.sv
module bsync_rx_filter_tb;
  localparam int W = 8;
  localparam int ENTRIES = 8;
  localparam int IDX_W = 3;
  localparam logic [W-1:0] SY = 8'h32;
  localparam logic [W-1:0] DL = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_char = '0;
  logic [W-1:0] sync_char = SY;
  logic sync_en = 1'b1;
  logic [W-1:0] dle_char = DL;
  logic dle_en = 1'b1;
  logic transparent = 1'b1;
  logic hunt = 1'b0;
  logic tbl_we = 1'b0;
  logic [IDX_W-1:0] tbl_idx = '0;
  logic tbl_ent_valid = 1'b0;
  logic [W-1:0] tbl_ent_char = '0;
  logic tbl_ent_close = 1'b0;
  logic out_valid, out_write, out_bcs, out_close, out_dle_err, out_ctl_irq;
  logic [W-1:0] out_char;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bsync_rx_filter #(.W(W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dut (.*);

  // expected vector: {valid, write, bcs, close, dle_err, irq}
  task automatic check(input string req, input logic [5:0] exp, input logic [W-1:0] ch);
    logic [5:0] got;
    got = {out_valid, out_write, out_bcs, out_close, out_dle_err, out_ctl_irq};
    checks++;
    if (got !== exp || (exp[5] && out_char !== ch)) begin
      fails++;
      $display("FAIL %s: got %b char %h, expected %b char %h", req, got, out_char, exp, ch);
    end
  endtask

  task automatic send(input logic [W-1:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_chk(input string req, input logic [W-1:0] c, input logic [5:0] exp);
    send(c);
    check(req, exp, c);
  endtask

  task automatic tbl_load(input int idx, input logic v, input logic [W-1:0] c, input logic cl);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IDX_W'(idx); tbl_ent_valid = v; tbl_ent_char = c; tbl_ent_close = cl;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  localparam logic [5:0] E_DATA = 6'b111000;
  localparam logic [5:0] E_DROP = 6'b100000;
  localparam logic [5:0] E_CLSW = 6'b111100;
  localparam logic [5:0] E_IRQ  = 6'b100001;
  localparam logic [5:0] E_ERR  = 6'b100110;

  task automatic t_reset;
    check("R1 reset outputs", 6'b000000, '0);
    send_chk("R1 empty table gives error", DL, E_DROP);
    send_chk("R1 empty table gives error", 8'h03, E_ERR);
    send_chk("R9 normal after close", 8'h41, E_DATA);
  endtask

  task automatic t_sync;
    send_chk("R2 sync stripped", SY, E_DROP);
    hunt = 1'b1;
    send_chk("R3 sync data in hunt", SY, E_DATA);
    hunt = 1'b0; sync_en = 1'b0;
    send_chk("R3 sync data when disabled", SY, E_DATA);
    sync_en = 1'b1;
    send_chk("R11 top bit differs", SY ^ 8'h80, E_DATA);
  endtask

  task automatic t_escape;
    send_chk("R4 dle dropped", DL, E_DROP);
    send_chk("R5 dle sync dropped", SY, E_DROP);
    send_chk("R5 back to normal", 8'h03, E_DATA);
    send_chk("R4 dle dropped", DL, E_DROP);
    send_chk("R6 dle dle kept", DL, E_DATA);
    send_chk("R6 back to normal", 8'h41, E_DATA);
  endtask

  task automatic t_table;
    tbl_load(0, 1'b1, 8'h03, 1'b1);
    tbl_load(1, 1'b1, 8'h05, 1'b0);
    tbl_load(2, 1'b0, 8'h07, 1'b1);
    tbl_load(3, 1'b1, 8'h05, 1'b1);
    send(DL);
    send_chk("R7 close entry", 8'h03, E_CLSW);
    send_chk("R9 normal after close", 8'h03, E_DATA);
    send(DL);
    send_chk("R8 irq entry", 8'h05, E_IRQ);
    send(DL);
    send_chk("R12 invalid entry ignored", 8'h07, E_ERR);
    send(DL);
    send_chk("R9 miss error", 8'h55, E_ERR);
    send_chk("R9 normal after error", 8'h55, E_DATA);
  endtask

  task automatic t_no_escape;
    dle_en = 1'b0;
    send_chk("R10 dle data when disabled", DL, E_DATA);
    send_chk("R10 no escape entered", 8'h55, E_DATA);
    dle_en = 1'b1; transparent = 1'b0;
    send_chk("R10 dle data when not transparent", DL, E_DATA);
    send_chk("R10 no escape entered", 8'h55, E_DATA);
    transparent = 1'b1;
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R13 no strobe no action", 6'b000000, '0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sync();
        t_escape();
        t_table();
        t_no_escape();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule